// File: doc/BRIEF.md
# Phase-Opposed Multicarrier PWM Modulator for an 11-Level Inverter

This block produces the seven gate commands for a single-phase, eleven-level inverter built from seven switches. A digital sinusoidal reference is compared against ten triangular carriers. The carriers sit in contiguous bands, five above zero and five below. The lower five run in antiphase to the upper five. The comparison result is a signed level from -5 to +5. Each non-zero level turns on one magnitude switch and one polarity switch.

All ten carriers come from one shared up/down counter. Each carrier adds a fixed band offset, and the lower carriers use the mirrored count. The reference comes from a phase accumulator that feeds a quarter-wave sine table, scaled by an amplitude setting given in carrier counts. The modulation index is the amplitude setting divided by five carrier band heights. Whenever the applied level changes, every gate is held off for a programmable dead time before the new pair turns on. A low enable forces every gate off.

Top module: `pod_modulator`

## Requirements
- R1: The level code `level_o` is a 4-bit two's-complement value in the range -5 to +5, so eleven distinct levels exist. Bit i of `gates_o` drives switch S(i+1), so bit 0 is S1 and bit 6 is S7. At full amplitude, all eleven level codes appear over one reference period.
- R2: For an applied level +k with k from 1 to 5, `gates_o` has bit k-1 (Sk) and bit 6 (S7) set, and every other bit clear.
- R3: For an applied level -k, `gates_o` has bit 5-k (switch S(6-k)) and bit 5 (S6) set, and every other bit clear. Level -5 therefore uses S1 with S6.
- R4: For applied level 0, all seven gates are off. While a dead time is running, all gates are also off, and `level_o` keeps the previous level.
- R5: The carrier counter c counts up and down between 0 and `top_i`. The band height is H = `top_i`+1. Upper carrier j (j = 0 to 4) equals j·H + c. Lower carrier j equals -(j+1)·H + (`top_i` - c), which is in antiphase with the upper carriers.
- R6: A 16-bit phase accumulator adds `step_i` on every clock, so one reference period lasts 65536/`step_i` clocks. The top two phase bits select the quadrant, and the next four bits index a 16-entry quarter-sine table whose peak is 255. The reference magnitude is floor(sine·`amp_i`/256). The reference is negative in the second half-period.
- R7: The raw level is the number of upper carriers the reference strictly exceeds, minus the number of lower carriers it does not exceed, clamped to ±5. Let p = floor(255·`amp_i`/256). The extreme levels reached over a period are then ±min(5, ceil(p/H)). For H = 16 and `amp_i` = 67 (index 0.84), the extremes are ±5.
- R8: When the raw level differs from the applied level and `dead_i` is non-zero, the gates go all-off for exactly `dead_i` clocks. The new level then appears on `level_o` together with its gate pair. With `dead_i` = 0, the new pair is applied directly.
- R9: The gates are either all off, or exactly one of bits 0 to 4 together with exactly one of bits 5 and 6. Two different non-zero gate patterns never follow each other on consecutive clocks unless `dead_i` was 0.
- R10: During reset, and on the clock after `en_i` is sampled low, `gates_o` and `level_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Output enable; low forces all gates off |
| amp_i | input | AMP_W (10) | Reference peak in carrier counts |
| step_i | input | PHASE_W (16) | Phase increment per clock |
| top_i | input | CNT_W (6) | Carrier counter top value; band height is top_i+1 |
| dead_i | input | DEAD_W (4) | Dead-time length in clocks |
| gates_o | output | 7 | Switch commands S1 (bit 0) to S7 (bit 6) |
| level_o | output | 4 | Applied signed level code |

## Verification
The assertions check on every clock that the gates form a legal pair, that the gate polarity agrees with the sign of the level code, and that no pair swaps straight to another pair unless the dead time is zero. They also check that an enable sampled low blanks the outputs, that the carrier count moves by at most one step, and that the reference never exceeds the amplitude setting. Only the bench scenarios can show the modulation results. These are the extreme levels reached for each amplitude and band height, all eleven levels appearing at full index, the exact all-off run length for each dead-time setting, and the reference period that follows from the phase step.

// File: rtl/pod_pkg.sv
package pod_pkg;
  localparam int NUM_BANDS = 5;
  localparam int GATE_W    = 7;
  localparam int LVL_W     = 4;

  typedef logic signed [LVL_W-1:0] lvl_t;
  typedef enum logic {ST_RUN, ST_DEAD} gate_st_e;

  // Level +k -> Sk and S7; level -k -> S(6-k) and S6; zero -> all off
  function automatic logic [GATE_W-1:0] lvl_to_gates(lvl_t l);
    logic [GATE_W-1:0] g;
    int k;
    g = '0;
    k = int'(l);
    if (k > 0) begin
      g[6]   = 1'b1;
      g[k-1] = 1'b1;
    end else if (k < 0) begin
      g[5]   = 1'b1;
      g[5+k] = 1'b1;
    end
    return g;
  endfunction
endpackage

// File: rtl/pod_carrier.sv
module pod_carrier #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      if (cnt_o >= top_i) begin
        up_q <= 1'b0;
        if (cnt_o != '0) cnt_o <= cnt_o - 1'b1;
      end else begin
        cnt_o <= cnt_o + 1'b1;
      end
    end else begin
      if (cnt_o == '0) begin
        up_q <= 1'b1;
        if (top_i != '0) cnt_o <= cnt_o + 1'b1;
      end else begin
        cnt_o <= cnt_o - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pod_ref.sv
module pod_ref #(
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 10,
  parameter int REF_W   = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PHASE_W-1:0]      step_i,
  input  logic [AMP_W-1:0]        amp_i,
  output logic signed [REF_W-1:0] ref_o
);
  localparam int SIN_W = 8;
  localparam int PROD_W = AMP_W + SIN_W;

  logic [PHASE_W-1:0] phase_q;
  logic [1:0]         quad;
  logic [3:0]         idx, qidx;
  logic [SIN_W-1:0]   sin_v;
  logic [PROD_W-1:0]  prod;
  logic [AMP_W-1:0]   mag;
  logic signed [REF_W-1:0] mag_s;

  // Quarter sine sampled at half-step offsets, peak 255
  function automatic logic [SIN_W-1:0] qsin(logic [3:0] i);
    case (i)
      4'd0:  qsin = 8'd13;
      4'd1:  qsin = 8'd37;
      4'd2:  qsin = 8'd62;
      4'd3:  qsin = 8'd86;
      4'd4:  qsin = 8'd109;
      4'd5:  qsin = 8'd131;
      4'd6:  qsin = 8'd152;
      4'd7:  qsin = 8'd171;
      4'd8:  qsin = 8'd189;
      4'd9:  qsin = 8'd205;
      4'd10: qsin = 8'd219;
      4'd11: qsin = 8'd230;
      4'd12: qsin = 8'd240;
      4'd13: qsin = 8'd247;
      4'd14: qsin = 8'd252;
      default: qsin = 8'd255;
    endcase
  endfunction

  always_comb begin
    quad  = phase_q[PHASE_W-1 -: 2];
    idx   = phase_q[PHASE_W-3 -: 4];
    qidx  = quad[0] ? (4'd15 - idx) : idx;
    sin_v = qsin(qidx);
    prod  = {{AMP_W{1'b0}}, sin_v} * {{SIN_W{1'b0}}, amp_i};
    mag   = prod[PROD_W-1:SIN_W];
    mag_s = $signed({{(REF_W-AMP_W){1'b0}}, mag});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      ref_o   <= '0;
    end else begin
      phase_q <= phase_q + step_i;
      ref_o   <= quad[1] ? -mag_s : mag_s;
    end
  end
endmodule

// File: rtl/pod_compare.sv
module pod_compare
  import pod_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int REF_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [CNT_W-1:0]        top_i,
  input  logic signed [REF_W-1:0] ref_i,
  output lvl_t                    lvl_o
);
  localparam int PAD = REF_W - CNT_W;
  localparam logic signed [REF_W-1:0] ONE = 1;

  logic signed [REF_W-1:0] top_s, cnt_s, h_s;
  logic [NUM_BANDS-1:0] above, not_above;
  logic [3:0] up_n, lo_n;
  logic signed [4:0] diff;
  lvl_t lvl_d;

  assign top_s = $signed({{PAD{1'b0}}, top_i});
  assign cnt_s = $signed({{PAD{1'b0}}, cnt_i});
  assign h_s   = top_s + ONE;

  for (genvar j = 0; j < NUM_BANDS; j++) begin : g_band
    localparam logic signed [REF_W-1:0] JS = j;
    logic signed [REF_W-1:0] up_v, lo_v;
    assign up_v = h_s * JS + cnt_s;
    assign lo_v = top_s - cnt_s - h_s * (JS + ONE);
    assign above[j]     = ref_i > up_v;
    assign not_above[j] = ref_i <= lo_v;
  end

  always_comb begin
    up_n = '0;
    lo_n = '0;
    for (int j = 0; j < NUM_BANDS; j++) begin
      up_n = up_n + 4'(above[j]);
      lo_n = lo_n + 4'(not_above[j]);
    end
    diff = $signed({1'b0, up_n}) - $signed({1'b0, lo_n});
    if (diff > 5'sd5)       lvl_d = 4'sd5;
    else if (diff < -5'sd5) lvl_d = -4'sd5;
    else                    lvl_d = diff[3:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_o <= '0;
    else         lvl_o <= lvl_d;
  end
endmodule

// File: rtl/pod_gate_ctrl.sv
module pod_gate_ctrl
  import pod_pkg::*;
#(
  parameter int DEAD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DEAD_W-1:0] dead_i,
  input  lvl_t              target_i,
  output logic [GATE_W-1:0] gates_o,
  output lvl_t              lvl_o
);
  gate_st_e          st_q;
  logic [DEAD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_RUN;
      cnt_q   <= '0;
      gates_o <= '0;
      lvl_o   <= '0;
    end else if (!en_i) begin
      st_q    <= ST_RUN;
      cnt_q   <= '0;
      gates_o <= '0;
      lvl_o   <= '0;
    end else begin
      case (st_q)
        ST_RUN: begin
          if (target_i != lvl_o) begin
            if (dead_i == '0) begin
              lvl_o   <= target_i;
              gates_o <= lvl_to_gates(target_i);
            end else begin
              st_q    <= ST_DEAD;
              cnt_q   <= dead_i - 1'b1;
              gates_o <= '0;
            end
          end
        end
        default: begin
          if (cnt_q == '0) begin
            st_q    <= ST_RUN;
            lvl_o   <= target_i;
            gates_o <= lvl_to_gates(target_i);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pod_modulator.sv
module pod_modulator
  import pod_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 10,
  parameter int CNT_W   = 6,
  parameter int DEAD_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [AMP_W-1:0]   amp_i,
  input  logic [PHASE_W-1:0] step_i,
  input  logic [CNT_W-1:0]   top_i,
  input  logic [DEAD_W-1:0]  dead_i,
  output logic [6:0]         gates_o,
  output logic [3:0]         level_o
);
  localparam int REF_W = ((AMP_W > CNT_W + 3) ? AMP_W : CNT_W + 3) + 2;

  logic [CNT_W-1:0]        car_cnt;
  logic signed [REF_W-1:0] ref_val;
  lvl_t                    raw_lvl, app_lvl;

  pod_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .top_i (top_i),
    .cnt_o (car_cnt)
  );

  pod_ref #(.PHASE_W(PHASE_W), .AMP_W(AMP_W), .REF_W(REF_W)) u_ref (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step_i),
    .amp_i (amp_i),
    .ref_o (ref_val)
  );

  pod_compare #(.CNT_W(CNT_W), .REF_W(REF_W)) u_cmp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_i (car_cnt),
    .top_i (top_i),
    .ref_i (ref_val),
    .lvl_o (raw_lvl)
  );

  pod_gate_ctrl #(.DEAD_W(DEAD_W)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .dead_i  (dead_i),
    .target_i(raw_lvl),
    .gates_o (gates_o),
    .lvl_o   (app_lvl)
  );

  assign level_o = app_lvl;
endmodule

// File: rtl/pod_modulator_chk.sv
module pod_modulator_chk #(
  parameter int AMP_W  = 10,
  parameter int CNT_W  = 6,
  parameter int DEAD_W = 4,
  parameter int REF_W  = 12
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    en_i,
  input logic [AMP_W-1:0]        amp_i,
  input logic [DEAD_W-1:0]       dead_i,
  input logic [6:0]              gates_o,
  input logic [3:0]              level_o,
  input logic [CNT_W-1:0]        car_cnt_i,
  input logic signed [REF_W-1:0] ref_i
);
  logic signed [REF_W:0] ref_abs;
  logic signed [REF_W:0] amp_ext;
  logic signed [3:0]     lvl_s;

  assign ref_abs = (ref_i < 0) ? -{ref_i[REF_W-1], ref_i} : {ref_i[REF_W-1], ref_i};
  assign amp_ext = $signed({{(REF_W+1-AMP_W){1'b0}}, amp_i});
  assign lvl_s   = $signed(level_o);

  // R9: all off, or one magnitude switch plus one polarity switch
  a_r9_pair_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gates_o == 7'd0) ||
    (($countones(gates_o[4:0]) == 1) && ($countones(gates_o[6:5]) == 1)));

  // R2 R3 R4: polarity switch agrees with the sign of the level code
  a_r2_pos_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_s > 0) |-> !gates_o[5]);
  a_r3_neg_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_s < 0) |-> !gates_o[6]);
  a_r4_zero_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_s == 0) |-> (gates_o == 7'd0));

  // R8: no direct pair-to-pair swap unless dead time is zero
  a_r8_dead_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gates_o != 7'd0) && ($past(gates_o) != 7'd0) && (gates_o != $past(gates_o)))
      |-> ($past(dead_i) == '0));

  // R10: enable low blanks the outputs on the next clock
  a_r10_enable_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ((gates_o == 7'd0) && (level_o == 4'd0)));

  // R5: carrier counter moves by at most one count per clock
  a_r5_carrier_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (car_cnt_i == $past(car_cnt_i)) ||
    (car_cnt_i == $past(car_cnt_i) + 1'b1) ||
    (car_cnt_i == $past(car_cnt_i) - 1'b1));

  // R6: reference magnitude never exceeds the amplitude setting
  a_r6_ref_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_abs <= $past(amp_ext));
endmodule

bind pod_modulator pod_modulator_chk #(
  .AMP_W (AMP_W),
  .CNT_W (CNT_W),
  .DEAD_W(DEAD_W),
  .REF_W (REF_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .amp_i    (amp_i),
  .dead_i   (dead_i),
  .gates_o  (gates_o),
  .level_o  (level_o),
  .car_cnt_i(car_cnt),
  .ref_i    (ref_val)
);

// File: tb/pod_modulator_test.sv
`timescale 1ns/1ps
module pod_modulator_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [9:0]  amp_i = '0;
  logic [15:0] step_i = '0;
  logic [5:0]  top_i = '0;
  logic [3:0]  dead_i = '0;
  logic [6:0]  gates_o;
  logic [3:0]  level_o;

  pod_modulator uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .amp_i(amp_i),
    .step_i(step_i), .top_i(top_i), .dead_i(dead_i),
    .gates_o(gates_o), .level_o(level_o)
  );

  always #2.5 clk_i = ~clk_i;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  int maxl, minl, dec_bad, pair_bad, trans_cnt, trans_bad, nz_cnt;
  int zrun = 0, prevl = 0, dt_exp = 0, nev = 0;
  bit dt_chk = 1'b0, armed = 1'b0;
  bit [10:0] seen;
  longint cyc = 0;
  longint ev [0:3];

  function automatic logic [6:0] exp_gates(int l);
    logic [6:0] g = '0;
    if (l > 0) begin g[6] = 1'b1; g[l-1] = 1'b1; end
    else if (l < 0) begin g[5] = 1'b1; g[5+l] = 1'b1; end
    return g;
  endfunction

  function automatic int peak_lvl(int amp, int h);
    int p = (255 * amp) / 256;
    int c;
    if (p == 0) return 0;
    c = (p - 1) / h + 1;
    return (c > 5) ? 5 : c;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_stats();
    maxl = -99; minl = 99; seen = '0;
    dec_bad = 0; pair_bad = 0; trans_cnt = 0; trans_bad = 0; nz_cnt = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      logic [6:0] g;
      int lv;
      @(posedge clk_i);
      #1;
      g  = gates_o;
      lv = int'($signed(level_o));
      cyc++;
      if (lv > maxl) maxl = lv;
      if (lv < minl) minl = lv;
      if (lv >= -5 && lv <= 5) seen[lv+5] = 1'b1;
      if (g != 7'd0 || lv != 0) nz_cnt++;
      if (!(g == 7'd0 || g == exp_gates(lv))) dec_bad++;
      if ($countones(g) > 2 ||
          (g != 7'd0 && !(g[5] ^ g[6])) ||
          (g != 7'd0 && $countones(g[4:0]) != 1)) pair_bad++;
      if (lv != prevl && dt_chk && prevl != 0) begin
        trans_cnt++;
        if (zrun != dt_exp) trans_bad++;
      end
      zrun  = (g == 7'd0) ? zrun + 1 : 0;
      prevl = lv;
      if (lv == -5) armed = 1'b1;
      if (lv == 5 && armed) begin
        armed = 1'b0;
        if (nev < 4) ev[nev] = cyc;
        nev++;
      end
    end
  endtask

  task automatic sweep(int amp, int top, string tag);
    int e;
    top_i = 6'(top);
    amp_i = 10'(amp);
    run(300);
    clear_stats();
    run(8192);
    e = peak_lvl(amp, top + 1);
    check(maxl == e, {tag, " max level"}, maxl, e);
    check(minl == -e, {tag, " min level"}, minl, -e);
    check(dec_bad == 0, "R2 R3 R4 gate decode vs level", dec_bad, 0);
    check(pair_bad == 0, "R9 gate pair shape", pair_bad, 0);
  endtask

  task automatic freq_run(int step);
    longint per = 65536 / step;
    step_i = 16'(step);
    run(200);
    nev = 0; armed = 1'b0;
    run(int'(3 * per + 200));
    check(nev >= 3, "R6 period events", nev, 3);
    if (nev >= 3) begin
      longint d1 = ev[1] - ev[0];
      longint d2 = ev[2] - ev[1];
      check(d1 > per - 64 && d1 < per + 64, "R6 reference period", d1, per);
      check(d2 > per - 64 && d2 < per + 64, "R6 reference period", d2, per);
    end
  endtask

  initial begin
    repeat (198000) @(posedge clk_i);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(posedge clk_i);
    #1;
    check(gates_o == 7'd0, "R10 reset gates", gates_o, 0);
    check(level_o == 4'd0, "R10 reset level", level_o, 0);
    rst_ni = 1'b1;
    en_i = 1'b1; top_i = 6'd15; step_i = 16'd8; dead_i = 4'd1;

    // R7 R5 peak level versus amplitude and band height
    sweep(0, 15, "R7 amp 0");
    sweep(16, 15, "R7 amp 1H");
    sweep(32, 15, "R7 amp 2H");
    sweep(48, 15, "R7 amp 3H");
    sweep(64, 15, "R7 amp 4H");
    sweep(80, 15, "R7 amp 5H");
    check(seen == 11'h7ff, "R1 all eleven levels seen", seen, 11'h7ff);
    sweep(112, 15, "R7 clamp");
    sweep(67, 15, "R7 index 0.84");
    sweep(24, 7, "R5 band height 8");

    // R8 dead-time length
    top_i = 6'd15; amp_i = 10'd67;
    for (int k = 0; k < 4; k++) begin
      int dts [4] = '{0, 1, 3, 7};
      dead_i = 4'(dts[k]);
      dt_exp = dts[k];
      run(200);
      clear_stats();
      dt_chk = 1'b1;
      run(8192);
      dt_chk = 1'b0;
      check(trans_cnt > 0, "R8 transitions observed", trans_cnt, 1);
      check(trans_bad == 0, "R8 all-off run length", trans_bad, 0);
      check(pair_bad == 0, "R9 gate pair shape", pair_bad, 0);
    end

    // R10 enable low
    dead_i = 4'd1; amp_i = 10'd80;
    run(100);
    en_i = 1'b0;
    clear_stats();
    run(50);
    check(nz_cnt == 0, "R10 enable low outputs off", nz_cnt, 0);
    en_i = 1'b1;
    clear_stats();
    run(400);
    check(nz_cnt > 0, "R10 outputs resume", nz_cnt, 1);

    // R6 reference period
    freq_run(8);
    freq_run(16);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule